// File: doc/BRIEF.md
# Dual-Width Register ALU with Byte Swap

This unit is the arithmetic stage of a 64-bit register machine. Each transaction carries a decoded 8-bit opcode, the current destination register value, a source register value and a 32-bit immediate. The unit returns the new destination value. The low three opcode bits pick a narrow (32-bit) or a wide (64-bit) operating class. Both classes share one operation table, so every operation code means the same thing at either width. A byte-order conversion operation works on the destination alone. It reuses the operand-select bit to choose the target byte order and takes its width from the immediate.

The result passes through one registered output stage. Valid/ready handshakes sit on both sides, so an upstream issue stage and a downstream writeback stage can each stall the unit. Encodings the unit cannot execute raise an illegal flag alongside the data, and the destination value passes through unchanged.

Top module: `dual_width_alu`

## Requirements
- R1: Opcode bits [2:0] = 3'h7 selects the wide class, which operates on full 64-bit operands. 3'h4 selects the narrow class, which uses only bits [31:0] of both operands and zero-extends its result into bits [63:32]. Any other class value is illegal.
- R2: Opcode bit 3 selects the second operand: 0 picks the immediate and 1 picks the source register. The wide class sign-extends the immediate to 64 bits; the narrow class uses it as is.
- R3: Opcode bits [7:4] pick the operation: 0 add, 1 subtract, 2 multiply (low half kept), 3 unsigned divide, 4 or, 5 and, 10 xor, 11 move (result = second operand).
- R4: Code 6 is a left shift, 7 a logical right shift and 12 an arithmetic right shift of the destination. The shift amount is the second operand masked to 5 bits in the narrow class and to 6 bits in the wide class.
- R5: Code 8 returns the two's-complement negation of the destination at the class width. The second operand has no effect.
- R6: Unsigned division by zero gives 0. Modulo (code 9) by zero gives the destination at the class width (narrow: zero-extended low half).
- R7: Code 13 converts byte order on the destination only. An immediate of 16, 32 or 64 gives the width. With bit 3 = 0 (little-endian host, little-endian target) the result is the destination truncated to that width and zero-extended. With bit 3 = 1 the bytes within that width are reversed and the result is zero-extended.
- R8: An unsupported class, an operation code of 14 or 15, or a byte-order immediate other than 16/32/64 sets the illegal output and returns the destination value unmodified.
- R9: in_ready is high whenever no result is held or the held result is being taken. A result appears one cycle after acceptance, and while out_valid is high and out_ready is low, the result and flag stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request carries an instruction |
| inReady | output | 1 | Unit can accept an instruction this cycle |
| opcode | input | 8 | Decoded opcode: class, operand select, operation |
| dstVal | input | 64 | Current destination register value |
| srcVal | input | 64 | Source register value |
| immVal | input | 32 | Instruction immediate |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result this cycle |
| result | output | 64 | New destination value |
| illegal | output | 1 | Instruction was not executable; result equals destination |

## Verification
The overlap of interest is a new instruction being accepted in the same cycle that the previous result is consumed. In that cycle the output register is both emptied and reloaded. The bench provokes this by issuing back-to-back instructions while out_ready follows a pseudo-random pattern, so accept-with-drain, accept-into-empty and stall cycles all occur. Each accepted instruction's expected value is queued and matched in order against the results actually taken, and any result held during a stall must not change from one cycle to the next.

// File: rtl/dwalu_pkg.sv
`timescale 1ns/1ps
package dwalu_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int IMM_W  = 32;
  localparam int OPC_W  = 8;
  localparam int BYTE_W = 8;
  localparam int NBYTES = DATA_W / BYTE_W;

  localparam logic [2:0] CLS_NARROW = 3'h4;
  localparam logic [2:0] CLS_WIDE   = 3'h7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB = 4'd1,  OP_MUL = 4'd2,  OP_DIV  = 4'd3,
    OP_OR   = 4'd4,  OP_AND = 4'd5,  OP_LSH = 4'd6,  OP_RSH  = 4'd7,
    OP_NEG  = 4'd8,  OP_MOD = 4'd9,  OP_XOR = 4'd10, OP_MOV  = 4'd11,
    OP_ARSH = 4'd12, OP_SWAP = 4'd13, OP_RSV14 = 4'd14, OP_RSV15 = 4'd15
  } aluOpE;

  typedef enum logic [1:0] { SW_16 = 2'd0, SW_32 = 2'd1, SW_64 = 2'd2 } swapWidthE;

  typedef struct packed {
    logic      load;
    logic      is64;
    logic      useReg;
    aluOpE     op;
    logic      swapBig;
    swapWidthE swapW;
    logic      illegal;
  } ctrlStrobesT;
endpackage

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import dwalu_pkg::*;
#(
  parameter int W = 64
) (
  input  aluOpE        op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] shAmt;
  assign shAmt = b[SH_W-1:0];

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV:  y = (b == '0) ? '0 : a / b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_LSH:  y = a << shAmt;
      OP_RSH:  y = a >> shAmt;
      OP_NEG:  y = '0 - a;
      OP_MOD:  y = (b == '0) ? a : a % b;
      OP_XOR:  y = a ^ b;
      OP_MOV:  y = b;
      OP_ARSH: y = W'($signed(a) >>> shAmt);
      default: y = a;
    endcase
  end
endmodule

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import dwalu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic [OPC_W-1:0] opcode,
  input  logic [IMM_W-1:0] immVal,
  output logic             outValid,
  input  logic             outReady,
  output logic             illegalQ,
  output ctrlStrobesT      str
);
  logic [2:0] opClass;
  logic       classOk, codeOk, widthOk, isSwap, illegalNow;
  swapWidthE  swW;

  assign opClass = opcode[2:0];
  assign classOk = (opClass == CLS_NARROW) || (opClass == CLS_WIDE);
  assign codeOk  = (opcode[7:4] <= 4'd13);
  assign isSwap  = (opcode[7:4] == 4'd13);

  always_comb begin
    widthOk = 1'b1;
    swW     = SW_64;
    case (immVal)
      IMM_W'(16): swW = SW_16;
      IMM_W'(32): swW = SW_32;
      IMM_W'(64): swW = SW_64;
      default:    widthOk = 1'b0;
    endcase
  end

  assign illegalNow = !classOk || !codeOk || (isSwap && !widthOk);
  assign inReady    = !outValid || outReady;

  always_comb begin
    str.load    = inValid && inReady;
    str.is64    = (opClass == CLS_WIDE);
    str.useReg  = opcode[3];
    str.op      = aluOpE'(opcode[7:4]);
    str.swapBig = opcode[3];
    str.swapW   = swW;
    str.illegal = illegalNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      illegalQ <= 1'b0;
    end else if (str.load) begin
      outValid <= 1'b1;
      illegalQ <= illegalNow;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(illegalQ));

  // R9
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> inReady);
endmodule

// File: rtl/alu_dpath.sv
`timescale 1ns/1ps
module alu_dpath
  import dwalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobesT       str,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] resultQ
);
  logic [DATA_W-1:0] immExt, opB, wideY, swapY, nextRes;
  logic [HALF_W-1:0] narrowY;

  assign immExt = str.is64 ? {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal}
                           : {{(DATA_W-IMM_W){1'b0}}, immVal};
  assign opB    = str.useReg ? srcVal : immExt;

  alu_core #(.W(DATA_W)) wideCore (
    .op(str.op), .a(dstVal), .b(opB), .y(wideY));

  alu_core #(.W(HALF_W)) narrowCore (
    .op(str.op), .a(dstVal[HALF_W-1:0]), .b(opB[HALF_W-1:0]), .y(narrowY));

  logic [DATA_W-1:0] be16, be32, be64;
  always_comb begin
    be16 = '0;
    be32 = '0;
    be64 = '0;
    for (int i = 0; i < 2; i++)
      be16[BYTE_W*i +: BYTE_W] = dstVal[BYTE_W*(1-i) +: BYTE_W];
    for (int i = 0; i < 4; i++)
      be32[BYTE_W*i +: BYTE_W] = dstVal[BYTE_W*(3-i) +: BYTE_W];
    for (int i = 0; i < NBYTES; i++)
      be64[BYTE_W*i +: BYTE_W] = dstVal[BYTE_W*(NBYTES-1-i) +: BYTE_W];
  end

  always_comb begin
    case (str.swapW)
      SW_16:   swapY = str.swapBig ? be16 : {{(DATA_W-16){1'b0}}, dstVal[15:0]};
      SW_32:   swapY = str.swapBig ? be32 : {{(DATA_W-32){1'b0}}, dstVal[31:0]};
      default: swapY = str.swapBig ? be64 : dstVal;
    endcase
  end

  always_comb begin
    if (str.illegal)              nextRes = dstVal;
    else if (str.op == OP_SWAP)   nextRes = swapY;
    else if (str.is64)            nextRes = wideY;
    else                          nextRes = {{(DATA_W-HALF_W){1'b0}}, narrowY};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        resultQ <= '0;
    else if (str.load) resultQ <= nextRes;
  end

  // R8
  illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.load && str.illegal |=> resultQ == $past(dstVal));

  // R1
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.load && !str.illegal && !str.is64 && str.op != OP_SWAP |=> resultQ[DATA_W-1:HALF_W] == '0);

  // R7
  swap16_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.load && !str.illegal && str.op == OP_SWAP && str.swapW == SW_16 |=> resultQ[DATA_W-1:16] == '0);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !str.load |=> $stable(resultQ));
endmodule

// File: rtl/dual_width_alu.sv
`timescale 1ns/1ps
module dual_width_alu
  import dwalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  ctrlStrobesT str;

  alu_ctrl ctrlU (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .opcode(opcode), .immVal(immVal), .outValid(outValid),
    .outReady(outReady), .illegalQ(illegal), .str(str));

  alu_dpath dpathU (
    .clk(clk), .rst_n(rst_n), .str(str), .dstVal(dstVal),
    .srcVal(srcVal), .immVal(immVal), .resultQ(result));
endmodule

// File: tb/tb_dual_width_alu.sv
`timescale 1ns/1ps
module tb_dual_width_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  opcode = '0;
  logic [63:0] dstVal = '0, srcVal = '0;
  logic [31:0] immVal = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] result;
  logic        illegal;

  int checks = 0, errors = 0;
  logic stallMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  typedef struct { logic [64:0] exp; string tag; } itemT;
  itemT q[$];

  dual_width_alu dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = stallMode ? lfsr[0] : 1'b1;
  end

  function automatic logic [64:0] model(input logic [7:0] op, input logic [63:0] d,
                                        input logic [63:0] s, input logic [31:0] im);
    logic [2:0] cls;
    logic [3:0] code;
    logic [63:0] b, r;
    logic [31:0] a32, b32, r32;
    int n;
    cls = op[2:0];
    code = op[7:4];
    if (cls != 3'h4 && cls != 3'h7) return {1'b1, d};
    if (code > 4'd13) return {1'b1, d};
    if (code == 4'd13) begin
      if (im == 32'd16) n = 2;
      else if (im == 32'd32) n = 4;
      else if (im == 32'd64) n = 8;
      else return {1'b1, d};
      r = '0;
      for (int i = 0; i < 8; i++)
        if (i < n) r[8*i +: 8] = op[3] ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
      return {1'b0, r};
    end
    if (cls == 3'h7) begin
      b = op[3] ? s : {{32{im[31]}}, im};
      case (code)
        4'd0: r = d + b;   4'd1: r = d - b;   4'd2: r = d * b;
        4'd3: r = (b == 0) ? 64'd0 : d / b;
        4'd4: r = d | b;   4'd5: r = d & b;
        4'd6: r = d << b[5:0];  4'd7: r = d >> b[5:0];
        4'd8: r = -d;
        4'd9: r = (b == 0) ? d : d % b;
        4'd10: r = d ^ b;  4'd11: r = b;
        default: r = $signed(d) >>> b[5:0];
      endcase
      return {1'b0, r};
    end
    a32 = d[31:0];
    b32 = op[3] ? s[31:0] : im;
    case (code)
      4'd0: r32 = a32 + b32;   4'd1: r32 = a32 - b32;   4'd2: r32 = a32 * b32;
      4'd3: r32 = (b32 == 0) ? 32'd0 : a32 / b32;
      4'd4: r32 = a32 | b32;   4'd5: r32 = a32 & b32;
      4'd6: r32 = a32 << b32[4:0];  4'd7: r32 = a32 >> b32[4:0];
      4'd8: r32 = -a32;
      4'd9: r32 = (b32 == 0) ? a32 : a32 % b32;
      4'd10: r32 = a32 ^ b32;  4'd11: r32 = b32;
      default: r32 = $signed(a32) >>> b32[4:0];
    endcase
    return {1'b0, 32'd0, r32};
  endfunction

  task automatic send(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                      input logic [31:0] im, input string tag);
    itemT it;
    @(negedge clk);
    inValid = 1'b1; opcode = op; dstVal = d; srcVal = s; immVal = im;
    while (!inReady) @(negedge clk);
    it.exp = model(op, d, s, im);
    it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  logic held = 1'b0;
  logic [64:0] heldVal;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        checks++;
        if (!outValid || {illegal, result} !== heldVal) begin
          errors++;
          $display("FAIL R9 stall hold: got v=%0b %h expected %h", outValid, {illegal, result}, heldVal);
        end
      end
      held = 1'b0;
      if (outValid && outReady) begin
        itemT it;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected result: got %h expected none", {illegal, result});
        end else begin
          it = q.pop_front();
          if ({illegal, result} !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.tag, {illegal, result}, it.exp);
          end
        end
      end else if (outValid) begin
        held = 1'b1;
        heldVal = {illegal, result};
      end
    end
  end

  task automatic runSet();
    // R1 class width
    send(8'h0F, 64'h0000_0001_FFFF_FFFF, 64'd1, 32'd0, "R1 wide add reg");
    send(8'h0C, 64'h0000_0001_FFFF_FFFF, 64'd1, 32'd0, "R1 narrow add reg");
    send(8'h0C, 64'hDEAD_BEEF_0000_0003, 64'hFFFF_0000_0000_0004, 32'd0, "R1 narrow ignores upper");
    // R2 operand select / immediate extension
    send(8'h07, 64'd5, 64'd100, 32'hFFFF_FFFF, "R2 wide imm sign-ext");
    send(8'h04, 64'd5, 64'd100, 32'hFFFF_FFFF, "R2 narrow imm");
    send(8'hB7, 64'd9, 64'd7, 32'h8000_0000, "R2 wide mov imm");
    // R3 operations
    send(8'h1F, 64'd10, 64'd30, 32'd0, "R3 wide sub");
    send(8'h2C, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_1111_1111, 32'd0, "R3 narrow mul");
    send(8'h3F, 64'hFFFF_FFFF_FFFF_FFF0, 64'd7, 32'd0, "R3 wide div");
    send(8'h47, 64'hF0F0, 64'd0, 32'h0F0F, "R3 wide or");
    send(8'h5C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_00FF_00FF_00FF, 32'd0, "R3 narrow and");
    send(8'hAF, 64'hAAAA_5555_AAAA_5555, 64'hFFFF_0000_FFFF_0000, 32'd0, "R3 wide xor");
    send(8'hBC, 64'hFFFF_FFFF_FFFF_FFFF, 64'hCAFE_BABE_1234_5678, 32'd0, "R3 narrow mov");
    // R4 shifts with masking
    send(8'h6C, 64'd1, 64'd33, 32'd0, "R4 narrow lsh masked");
    send(8'h6F, 64'd1, 64'd65, 32'd0, "R4 wide lsh masked");
    send(8'h74, 64'hFFFF_FFFF_8000_0000, 64'd0, 32'd4, "R4 narrow rsh");
    send(8'hC4, 64'h0000_0000_8000_0000, 64'd0, 32'd4, "R4 narrow arsh");
    send(8'hCF, 64'h8000_0000_0000_0000, 64'd63, 32'd0, "R4 wide arsh");
    // R5 negate
    send(8'h8F, 64'd1, 64'd99, 32'd0, "R5 wide neg");
    send(8'h84, 64'h0000_0007_0000_0001, 64'd0, 32'd55, "R5 narrow neg");
    // R6 divide/modulo by zero
    send(8'h3F, 64'd1234, 64'd0, 32'd0, "R6 wide div zero");
    send(8'h9F, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'd0, "R6 wide mod zero");
    send(8'h9C, 64'h1234_5678_9ABC_DEF0, 64'h1_0000_0000, 32'd0, "R6 narrow mod zero");
    send(8'h97, 64'd100, 64'd0, 32'd7, "R6 wide mod");
    // R7 byte order
    send(8'hD4, 64'h0102_0304_0506_0708, 64'd0, 32'd16, "R7 le16");
    send(8'hDC, 64'h0102_0304_0506_0708, 64'd0, 32'd16, "R7 be16");
    send(8'hDC, 64'h0102_0304_0506_0708, 64'd0, 32'd32, "R7 be32");
    send(8'hDC, 64'h0102_0304_0506_0708, 64'd0, 32'd64, "R7 be64");
    send(8'hD4, 64'h0102_0304_0506_0708, 64'd0, 32'd64, "R7 le64");
    // R8 illegal
    send(8'hDC, 64'h0102_0304_0506_0708, 64'd0, 32'd8, "R8 bad swap width");
    send(8'hEF, 64'h5555_AAAA_5555_AAAA, 64'd1, 32'd0, "R8 code 14");
    send(8'h05, 64'h1111_2222_3333_4444, 64'd1, 32'd0, "R8 bad class");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R9 reset state: got v=%0b r=%0b expected v=0 r=1", outValid, inReady);
    end
    runSet();
    stallMode = 1'b1;
    // R9 back-to-back with random backpressure
    runSet();
    runSet();
    stallMode = 1'b0;
    repeat (10) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9 results missing: got %0d pending expected 0", q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule